// File: doc/BRIEF.md
# Byte-wide PROM Programming Sequencer

This controller drives a byte-wide programmable memory through its programming pins on behalf of a host. After a start pulse it switches on the normal supply and waits for it to settle. It puts the memory into address-clear mode and raises the programming supplies in a safe order. Then, for each address in turn, it takes one byte from a valid/ready byte source and runs repeated timed write windows. Each write window is followed by inhibit mode and then a verify phase that compares the read-back bus with the byte.

When the byte first reads back correctly, the sequencer applies one more write. This extra write lasts the unit pulse multiplied by the number of attempts the byte needed. The sequencer then sets inhibit mode and issues four clock pulses, which step the memory's internal address by one. After the last byte it returns to address-clear mode and removes the programming supplies in reverse order, then reports done. A byte that never verifies within the attempt limit ends the run: the sequencer raises an error flag and reports the failing address. Every duration is a parameter counted in system clocks.

States: IDLE, SETTLE, CLEAR, RAISE, HV, FETCH, WRITE, WINH, VERIFY, EXTRA, XINH, CLK_HI, CLK_LO, HV_OFF, LOWER, DONE, ERROR. The transitions are:

- IDLE/DONE/ERROR go to SETTLE on start, or to DONE on start when the count is zero.
- SETTLE goes to CLEAR, then RAISE, then HV, then FETCH.
- FETCH goes to WRITE on a handshake.
- WRITE goes to WINH, then VERIFY.
- VERIFY goes to EXTRA on a match. On a mismatch it goes back to WRITE, or to HV_OFF once the attempt limit is reached.
- EXTRA goes to XINH, then CLK_HI, then CLK_LO.
- CLK_LO goes back to CLK_HI until four pulses are done. It then goes to FETCH, or to HV_OFF after the last address.
- HV_OFF goes to LOWER, then to DONE or ERROR.

Top module: `prom_prog_seq`

## Requirements
- R1: After reset the block is idle. `mode` is 4'b0000 (off), and `xclk`, `wr_oe`, `vdd_en`, `vdd_hi_en`, `vpp_en`, `src_ready`, `done` and `error` are all low.
- R2: A start with a nonzero `byte_count` raises `vdd_en` and holds `mode` at off for exactly SETTLE_CYC cycles. It then enters clear mode (4'b0001).
- R3: `vpp_en` is high only while `vdd_hi_en` is high, and it rises only while `mode` is clear. On shutdown `vpp_en` falls before `vdd_hi_en`.
- R4: `src_ready` is high only in inhibit mode (4'b1000) while a byte is awaited. The byte taken in the handshake is driven on `wr_data`, unchanged through every write window. `wr_oe` is high only in write mode (4'b0010).
- R5: Each write attempt holds write mode for exactly UNIT_CYC cycles. Inhibit mode follows, then verify mode (4'b0100), in which `rd_data` is compared with the byte.
- R6: On a verify mismatch below the attempt limit, another write, inhibit and verify round follows.
- R7: After the first matching verify, exactly one extra write window follows, lasting the attempt count times UNIT_CYC cycles.
- R8: After the extra write, the sequencer issues exactly four `xclk` pulses in inhibit mode, each high for CLK_HI_CYC cycles, and then moves to the next byte.
- R9: After the last of `byte_count` bytes, the sequencer sets clear mode, drops `vpp_en`, then drops `vdd_hi_en`. It then holds `done` high with `vdd_en` still high.
- R10: A mismatch on attempt MAX_TRY stops the run with no extra write. The sequencer powers down as in R9, raises `error` instead of `done`, and sets `fail_addr` to the zero-based index of the failing byte.
- R11: A start with `byte_count` of zero reports done without raising either programming supply.
- R12: A start while done or in error begins a new run and clears `error` and `fail_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a programming run |
| byte_count | input | ADDR_W | Number of bytes to program |
| src_valid | input | 1 | Byte source has a byte |
| src_ready | output | 1 | Sequencer accepts a byte |
| src_data | input | DATA_W | Byte from the source |
| rd_data | input | DATA_W | Read-back data from the memory |
| mode | output | 4 | Memory mode code |
| xclk | output | 1 | Address-advance clock to the memory |
| wr_data | output | DATA_W | Data driven to the memory |
| wr_oe | output | 1 | Drive enable for `wr_data` |
| vdd_en | output | 1 | Normal supply enable |
| vdd_hi_en | output | 1 | Raised supply enable |
| vpp_en | output | 1 | High programming voltage enable |
| done | output | 1 | Run completed |
| error | output | 1 | Run aborted on attempt limit |
| fail_addr | output | ADDR_W | Index of the byte that failed |

## Verification
The bound checker watches, on every cycle, the supply ordering, the rule that the data driver and the byte request each appear only in their own mode, and the stability of write data. It also checks that write is always followed by inhibit and inhibit by verify, that address clocks occur only in inhibit, and that the done and error flags never overlap. The bench alone can show the durations that depend on the run: the settle length, each unit write window, the extra write scaled by the attempt count, and the four-pulse address step. It also shows the retry and abort decisions, the failing index and the zero-count start. It does this with a memory model that accepts a byte only after a chosen number of write windows.

// File: rtl/prom_prog_pkg.sv
package prom_prog_pkg;
    localparam logic [3:0] MD_OFF     = 4'b0000;
    localparam logic [3:0] MD_CLEAR   = 4'b0001;
    localparam logic [3:0] MD_WRITE   = 4'b0010;
    localparam logic [3:0] MD_VERIFY  = 4'b0100;
    localparam logic [3:0] MD_INHIBIT = 4'b1000;

    typedef enum logic [4:0] {
        ST_IDLE, ST_SETTLE, ST_CLEAR, ST_RAISE, ST_HV, ST_FETCH,
        ST_WRITE, ST_WINH, ST_VERIFY, ST_EXTRA, ST_XINH,
        ST_CLK_HI, ST_CLK_LO, ST_HV_OFF, ST_LOWER, ST_DONE, ST_ERROR
    } pps_state_e;
endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pps_tries.sv
module pps_tries #(
    parameter int MAX_TRY = 25,
    parameter int W       = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         at_cap
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= inc ? W'(1) : '0;
        else if (inc) count <= count + 1'b1;
    end

    assign at_cap = (count >= W'(MAX_TRY));
endmodule

// File: rtl/prom_prog_seq.sv
module prom_prog_seq
    import prom_prog_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int UNIT_CYC   = 50000,
    parameter int SETTLE_CYC = 500,
    parameter int GAP_CYC    = 10,
    parameter int CLK_HI_CYC = 25,
    parameter int CLK_LO_CYC = 25,
    parameter int MAX_TRY    = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] byte_count,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    input  logic [DATA_W-1:0] rd_data,
    output logic [3:0]        mode,
    output logic              xclk,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_oe,
    output logic              vdd_en,
    output logic              vdd_hi_en,
    output logic              vpp_en,
    output logic              done,
    output logic              error,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam int TRY_W      = $clog2(MAX_TRY + 1);
    localparam int TMR_W      = $clog2(MAX_TRY * UNIT_CYC + SETTLE_CYC + 1) + 1;
    localparam int ADV_PULSES = 4;
    localparam int PULSE_W    = $clog2(ADV_PULSES);

    pps_state_e          state_q, state_d;
    logic                tmr_zero, tmr_load;
    logic [TMR_W-1:0]    tmr_val;
    logic [TRY_W-1:0]    tries;
    logic                at_cap, tries_clr, tries_inc;
    logic [ADDR_W-1:0]   addr_q, count_q, fail_q;
    logic [DATA_W-1:0]   byte_q;
    logic [PULSE_W-1:0]  pulse_q;
    logic                err_q;
    logic                can_start, verify_ok, last_pulse, last_byte;

    assign can_start  = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_ERROR);
    assign verify_ok  = (rd_data == byte_q);
    assign last_pulse = (pulse_q == PULSE_W'(ADV_PULSES - 1));
    assign last_byte  = ({1'b0, addr_q} + 1'b1) == {1'b0, count_q};

    pps_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    pps_tries #(.MAX_TRY(MAX_TRY), .W(TRY_W)) u_tries (
        .clk(clk), .rst_n(rst_n), .clr(tries_clr), .inc(tries_inc),
        .count(tries), .at_cap(at_cap)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d   = state_q;
        tries_clr = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_ERROR:
                if (start) state_d = (byte_count == '0) ? ST_DONE : ST_SETTLE;
            ST_SETTLE: if (tmr_zero) state_d = ST_CLEAR;
            ST_CLEAR:  if (tmr_zero) state_d = ST_RAISE;
            ST_RAISE:  if (tmr_zero) state_d = ST_HV;
            ST_HV:     if (tmr_zero) state_d = ST_FETCH;
            ST_FETCH:
                if (src_valid) begin
                    state_d   = ST_WRITE;
                    tries_clr = 1'b1;
                end
            ST_WRITE:  if (tmr_zero) state_d = ST_WINH;
            ST_WINH:   if (tmr_zero) state_d = ST_VERIFY;
            ST_VERIFY:
                if (tmr_zero) begin
                    if (verify_ok)   state_d = ST_EXTRA;
                    else if (at_cap) state_d = ST_HV_OFF;
                    else             state_d = ST_WRITE;
                end
            ST_EXTRA:  if (tmr_zero) state_d = ST_XINH;
            ST_XINH:   if (tmr_zero) state_d = ST_CLK_HI;
            ST_CLK_HI: if (tmr_zero) state_d = ST_CLK_LO;
            ST_CLK_LO:
                if (tmr_zero) begin
                    if (!last_pulse)    state_d = ST_CLK_HI;
                    else if (last_byte) state_d = ST_HV_OFF;
                    else                state_d = ST_FETCH;
                end
            ST_HV_OFF: if (tmr_zero) state_d = ST_LOWER;
            ST_LOWER:  if (tmr_zero) state_d = err_q ? ST_ERROR : ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign tries_inc = (state_d == ST_WRITE) && (state_q != ST_WRITE);
    assign tmr_load  = (state_d != state_q);

    // duration of the state being entered, minus one
    always_comb begin
        unique case (state_d)
            ST_SETTLE: tmr_val = TMR_W'(SETTLE_CYC - 1);
            ST_WRITE:  tmr_val = TMR_W'(UNIT_CYC - 1);
            ST_EXTRA:  tmr_val = TMR_W'(tries) * TMR_W'(UNIT_CYC) - 1'b1;
            ST_CLK_HI: tmr_val = TMR_W'(CLK_HI_CYC - 1);
            ST_CLK_LO: tmr_val = TMR_W'(CLK_LO_CYC - 1);
            ST_CLEAR, ST_RAISE, ST_HV, ST_WINH, ST_VERIFY,
            ST_XINH, ST_HV_OFF, ST_LOWER:
                       tmr_val = TMR_W'(GAP_CYC - 1);
            default:   tmr_val = '0;
        endcase
    end

    // run datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            count_q <= '0;
            fail_q  <= '0;
            byte_q  <= '0;
            pulse_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (can_start && start) begin
                count_q <= byte_count;
                addr_q  <= '0;
                fail_q  <= '0;
                pulse_q <= '0;
                err_q   <= 1'b0;
            end
            if (state_q == ST_FETCH && src_valid) byte_q <= src_data;
            if (state_q == ST_CLK_LO && tmr_zero) begin
                if (last_pulse) begin
                    pulse_q <= '0;
                    addr_q  <= addr_q + 1'b1;
                end else begin
                    pulse_q <= pulse_q + 1'b1;
                end
            end
            if (state_q == ST_VERIFY && tmr_zero && !verify_ok && at_cap) begin
                err_q  <= 1'b1;
                fail_q <= addr_q;
            end
        end
    end

    // outputs
    always_comb begin
        mode      = MD_OFF;
        xclk      = 1'b0;
        wr_oe     = 1'b0;
        vdd_en    = 1'b0;
        vdd_hi_en = 1'b0;
        vpp_en    = 1'b0;
        src_ready = 1'b0;
        done      = 1'b0;
        error     = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SETTLE: vdd_en = 1'b1;
            ST_CLEAR:  begin vdd_en = 1'b1; mode = MD_CLEAR; end
            ST_RAISE:  begin vdd_en = 1'b1; vdd_hi_en = 1'b1; mode = MD_CLEAR; end
            ST_HV:     begin vdd_en = 1'b1; vdd_hi_en = 1'b1; vpp_en = 1'b1; mode = MD_CLEAR; end
            ST_FETCH:  begin
                vdd_en = 1'b1; vdd_hi_en = 1'b1; vpp_en = 1'b1;
                mode = MD_INHIBIT; src_ready = 1'b1;
            end
            ST_WRITE, ST_EXTRA: begin
                vdd_en = 1'b1; vdd_hi_en = 1'b1; vpp_en = 1'b1;
                mode = MD_WRITE; wr_oe = 1'b1;
            end
            ST_WINH, ST_XINH, ST_CLK_LO: begin
                vdd_en = 1'b1; vdd_hi_en = 1'b1; vpp_en = 1'b1; mode = MD_INHIBIT;
            end
            ST_CLK_HI: begin
                vdd_en = 1'b1; vdd_hi_en = 1'b1; vpp_en = 1'b1;
                mode = MD_INHIBIT; xclk = 1'b1;
            end
            ST_VERIFY: begin
                vdd_en = 1'b1; vdd_hi_en = 1'b1; vpp_en = 1'b1; mode = MD_VERIFY;
            end
            ST_HV_OFF: begin vdd_en = 1'b1; vdd_hi_en = 1'b1; mode = MD_CLEAR; end
            ST_LOWER:  begin vdd_en = 1'b1; mode = MD_CLEAR; end
            ST_DONE:   begin vdd_en = 1'b1; done = 1'b1; end
            ST_ERROR:  begin vdd_en = 1'b1; error = 1'b1; end
            default:   ;
        endcase
    end

    assign wr_data   = byte_q;
    assign fail_addr = fail_q;
endmodule

// File: rtl/prom_prog_chk.sv
module prom_prog_chk
    import prom_prog_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       src_ready,
    input logic [3:0] mode,
    input logic       xclk,
    input logic [7:0] wr_data_lo,
    input logic       wr_oe,
    input logic       vdd_en,
    input logic       vdd_hi_en,
    input logic       vpp_en,
    input logic       done,
    input logic       error
);
    a_r3_hv_needs_raise: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_en |-> vdd_hi_en);

    a_r3_hv_rise_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vpp_en) |-> (mode == MD_CLEAR));

    a_r4_ready_in_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> (mode == MD_INHIBIT));

    a_r4_oe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_oe |-> (mode == MD_WRITE));

    a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_WRITE && $past(mode) == MD_WRITE) |-> $stable(wr_data_lo));

    a_r5_write_to_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_WRITE) |=> (mode == MD_WRITE || mode == MD_INHIBIT));

    a_r5_verify_from_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_VERIFY && $past(mode) != MD_VERIFY) |-> ($past(mode) == MD_INHIBIT));

    a_r8_clock_in_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        xclk |-> (mode == MD_INHIBIT));

    a_r9_done_powered_down: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!vpp_en && !vdd_hi_en && vdd_en));

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
endmodule

bind prom_prog_seq prom_prog_chk u_chk (
    .clk(clk), .rst_n(rst_n), .src_ready(src_ready), .mode(mode), .xclk(xclk),
    .wr_data_lo(wr_data[7:0]), .wr_oe(wr_oe), .vdd_en(vdd_en), .vdd_hi_en(vdd_hi_en),
    .vpp_en(vpp_en), .done(done), .error(error)
);

// File: tb/prom_prog_seq_bench.sv
module prom_prog_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 4;
    localparam int UNIT = 20;
    localparam int SETL = 10;
    localparam int GAP  = 3;
    localparam int CHI  = 2;
    localparam int CLO  = 2;
    localparam int MAXT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] byte_count = '0;
    logic src_valid = 1'b0;
    logic src_ready;
    logic [7:0] src_data = '0;
    logic [7:0] rd_data = '0;
    logic [3:0] mode;
    logic xclk, wr_oe, vdd_en, vdd_hi_en, vpp_en, done, error;
    logic [7:0] wr_data;
    logic [AW-1:0] fail_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    prom_prog_seq #(
        .ADDR_W(AW), .DATA_W(8), .UNIT_CYC(UNIT), .SETTLE_CYC(SETL), .GAP_CYC(GAP),
        .CLK_HI_CYC(CHI), .CLK_LO_CYC(CLO), .MAX_TRY(MAXT)
    ) u_prom_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .rd_data(rd_data), .mode(mode), .xclk(xclk), .wr_data(wr_data), .wr_oe(wr_oe),
        .vdd_en(vdd_en), .vdd_hi_en(vdd_hi_en), .vpp_en(vpp_en), .done(done),
        .error(error), .fail_addr(fail_addr)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] bytes [16];
    logic [7:0] mem   [16];
    int need [16], nwin [16], wcyc [16], firstlen [16], lastlen [16];
    int maddr, adv_cnt, pcnt, curlen, hirun;
    int settle_cnt, seen_clear, viol_pwr, viol_clk, hv_rises, bad_oe;
    int src_idx, src_n, pend;
    int cyc = 0;
    logic [3:0] prev_mode = 4'b0000;
    logic prev_xclk = 1'b0;
    logic prev_vpp = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // memory model and observers
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (vdd_en && mode == 4'b0000 && !done && !error && seen_clear == 0) settle_cnt++;
            if (mode == 4'b0001) begin
                seen_clear = 1;
                maddr = 0;
                pcnt = 0;
            end
            if (vpp_en && !vdd_hi_en) viol_pwr++;
            if (vpp_en && !prev_vpp) begin
                hv_rises++;
                if (mode != 4'b0001) viol_pwr++;
            end
            if (wr_oe && mode != 4'b0010) bad_oe++;
            if (mode == 4'b0010) begin
                curlen++;
                wcyc[maddr]++;
                mem[maddr] = wr_data;
                if (!wr_oe) bad_oe++;
            end else if (prev_mode == 4'b0010) begin
                if (nwin[maddr] == 0) firstlen[maddr] = curlen;
                lastlen[maddr] = curlen;
                nwin[maddr]++;
                curlen = 0;
            end
            if (xclk) hirun++;
            if (prev_xclk && !xclk) begin
                if (hirun != CHI) viol_clk++;
                hirun = 0;
            end
            if (xclk && !prev_xclk) begin
                pcnt++;
                if (pcnt == 4) begin
                    pcnt = 0;
                    maddr++;
                    adv_cnt++;
                end
            end
            if (mode == 4'b0100)
                rd_data = (nwin[maddr] >= need[maddr]) ? mem[maddr] : (mem[maddr] ^ 8'hA5);
            else
                rd_data = 8'h00;
        end
        prev_mode = mode;
        prev_xclk = xclk;
        prev_vpp  = vpp_en;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // byte source
    always @(negedge clk) begin
        if (pend != 0) begin
            src_idx++;
            pend = 0;
        end
        src_data  = bytes[src_idx[3:0]];
        src_valid = (src_idx < src_n);
        if (src_valid && src_ready) pend = 1;
    end

    task automatic clear_obs();
        for (int i = 0; i < 16; i++) begin
            nwin[i] = 0; wcyc[i] = 0; firstlen[i] = 0; lastlen[i] = 0; mem[i] = '0;
        end
        maddr = 0; adv_cnt = 0; pcnt = 0; curlen = 0; hirun = 0;
        settle_cnt = 0; seen_clear = 0; viol_pwr = 0; viol_clk = 0; hv_rises = 0; bad_oe = 0;
        src_idx = 0; pend = 0;
    endtask

    task automatic run(input int n);
        int guard;
        @(negedge clk);
        clear_obs();
        src_n = n;
        byte_count = AW'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && !error && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 20000, "R9 run ends", guard, 20000);
    endtask

    task automatic check_good(input int n, input string tag);
        chk(done == 1'b1, {tag, " R9 done"}, int'(done), 1);
        chk(error == 1'b0, {tag, " R12 no error"}, int'(error), 0);
        chk(settle_cnt == SETL, {tag, " R2 settle"}, settle_cnt, SETL);
        chk(vpp_en == 0 && vdd_hi_en == 0 && vdd_en == 1, {tag, " R9 supplies"},
            int'({vdd_en, vdd_hi_en, vpp_en}), 4);
        chk(viol_pwr == 0, {tag, " R3 order"}, viol_pwr, 0);
        chk(hv_rises == 1, {tag, " R3 one rise"}, hv_rises, 1);
        chk(bad_oe == 0, {tag, " R4 oe"}, bad_oe, 0);
        chk(viol_clk == 0, {tag, " R8 pulse width"}, viol_clk, 0);
        chk(adv_cnt == n, {tag, " R8 advances"}, adv_cnt, n);
        for (int i = 0; i < n; i++) begin
            chk(mem[i] == bytes[i], {tag, " R4 data"}, int'(mem[i]), int'(bytes[i]));
            chk(nwin[i] == need[i] + 1, {tag, " R6 windows"}, nwin[i], need[i] + 1);
            chk(firstlen[i] == UNIT, {tag, " R5 unit"}, firstlen[i], UNIT);
            chk(lastlen[i] == need[i] * UNIT, {tag, " R7 extra"}, lastlen[i], need[i] * UNIT);
            chk(wcyc[i] == 2 * need[i] * UNIT, {tag, " R7 total"}, wcyc[i], 2 * need[i] * UNIT);
        end
    endtask

    task automatic t_reset();
        chk(mode == 4'b0000 && !xclk && !wr_oe && !src_ready, "R1 mode/pins",
            int'({mode, xclk, wr_oe, src_ready}), 0);
        chk(!vdd_en && !vdd_hi_en && !vpp_en && !done && !error, "R1 supplies/flags",
            int'({vdd_en, vdd_hi_en, vpp_en, done, error}), 0);
    endtask

    task automatic t_single_try();
        bytes[0] = 8'h3C; bytes[1] = 8'h81; bytes[2] = 8'hF0;
        need[0] = 1; need[1] = 1; need[2] = 1;
        run(3);
        check_good(3, "single");
    endtask

    task automatic t_abort();
        bytes[0] = 8'h12; bytes[1] = 8'h34; bytes[2] = 8'h56;
        need[0] = 1; need[1] = MAXT + 2; need[2] = 1;
        run(3);
        chk(error == 1'b1 && done == 1'b0, "R10 error flag", int'({done, error}), 1);
        chk(fail_addr == 1, "R10 fail index", int'(fail_addr), 1);
        chk(nwin[1] == MAXT, "R10 no extra write", nwin[1], MAXT);
        chk(wcyc[1] == MAXT * UNIT, "R10 write cycles", wcyc[1], MAXT * UNIT);
        chk(adv_cnt == 1, "R10 stopped at index", adv_cnt, 1);
        chk(!vpp_en && !vdd_hi_en && viol_pwr == 0, "R10 R3 powered down",
            int'({vdd_hi_en, vpp_en}) + viol_pwr, 0);
    endtask

    task automatic t_retries();
        bytes[0] = 8'h5A; bytes[1] = 8'hC3; bytes[2] = 8'h0F; bytes[3] = 8'h99;
        need[0] = 2; need[1] = 3; need[2] = 1; need[3] = MAXT;
        run(4);
        chk(fail_addr == 0, "R12 fail cleared", int'(fail_addr), 0);
        check_good(4, "retry");
    endtask

    task automatic t_zero();
        run(0);
        chk(done == 1'b1 && error == 1'b0, "R11 done", int'({done, error}), 2);
        chk(hv_rises == 0 && !vdd_hi_en, "R11 no supplies", hv_rises + int'(vdd_hi_en), 0);
        chk(adv_cnt == 0 && nwin[0] == 0, "R11 no writes", adv_cnt + nwin[0], 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            bytes[i] = '0;
            need[i] = 1;
        end
        src_n = 0;
        clear_obs();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single_try();
        t_abort();
        t_retries();
        t_zero();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule